// File: doc/BRIEF.md
# Single-Slot Pipeline FIFO

This block is a one-word elastic buffer that sits between a producer and a consumer, both using a valid/ready handshake. It holds one stored word and a single occupancy flag. A word written in one cycle is offered to the consumer from the next cycle on. The buffer is therefore a full register stage: both the data path and the valid path are registered.

The block can drain and refill in the same cycle while it is occupied. The consumer takes the old word first, and the new word replaces it at the clock edge. To make this possible, the producer-side ready is formed combinationally from the consumer-side ready. With that one path, a steady stream passes through at one word per clock using only a single storage register. While the buffer is empty, the output data lane keeps the last word it carried, and the receiver must ignore it.

Top module: `pipe_fifo1`

## Requirements
- R1: While reset is asserted and after it is released, `deq_valid` is 0 and `enq_ready` is 1, and the stored data reads as zero.
- R2: `deq_valid` is 1 exactly when a word is held. An accepted write into an empty buffer makes `deq_valid` 1 in the next cycle, and `deq_data` then equals the written word.
- R3: While a word is held and `deq_ready` is 0, `enq_ready` is 0. An offered write is not taken, and `deq_data` and `deq_valid` stay unchanged in the next cycle.
- R4: A read of a held word (`deq_valid` and `deq_ready` both 1) with no write in the same cycle makes `deq_valid` 0 in the next cycle.
- R5: A read and a write in the same cycle deliver the old word in that cycle. In the next cycle `deq_valid` stays 1 and `deq_data` equals the new word.
- R6: `enq_ready` equals `deq_ready` in the same cycle whenever a word is held, and is 1 whenever the buffer is empty.
- R7: `deq_data` changes only on an accepted write. While the buffer is empty it keeps the last word written.
- R8: With `enq_valid` and `deq_ready` held at 1 from an empty buffer for N cycles, exactly N-1 words leave, one in every cycle after the first fill.
- R9: Under arbitrary stalls on both sides, the words leave in the order they were accepted, with none lost and none repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enq_valid | input | 1 | Producer offers a word |
| enq_ready | output | 1 | Buffer will take the offered word this cycle |
| enq_data | input | WIDTH | Word offered by the producer |
| deq_valid | output | 1 | A word is held and offered to the consumer |
| deq_ready | input | 1 | Consumer takes the offered word this cycle |
| deq_data | output | WIDTH | Held word |

## Verification
The bench targets the case where the buffer is full and a read and a write arrive together. A design that blocks the write there halves throughput, which the streaming count of R8 exposes. A design that keeps the old word there would repeat it and lose the new one, which the ordered scoreboard of R9 reports. A full buffer with a stalled consumer is also driven: a design that overwrites its slot anyway would drop the held word. Empty periods check that the data lane holds its last value rather than following the input bus.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

  // A handshake completes when both sides agree in the same cycle.
  function automatic logic hs_fire(input logic valid, input logic ready);
    return valid & ready;
  endfunction

  // The slot can take a word when empty or when it drains this cycle.
  function automatic logic slot_open(input logic occupied, input logic drain_req);
    return !occupied || drain_req;
  endfunction

  // Occupancy after the edge: a load fills it, a drain without load empties it.
  function automatic logic occ_next(input logic occupied, input logic load,
                                    input logic drain);
    return load || (occupied && !drain);
  endfunction

endpackage

// File: rtl/pfifo_ctrl.sv
module pfifo_ctrl
  import pfifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enq_valid,
  input  logic deq_ready,
  output logic enq_ready,
  output logic deq_valid,
  output logic load_evt,
  output logic drain_evt
);

  logic occ_q;

  assign deq_valid = occ_q;
  assign drain_evt = hs_fire(occ_q, deq_ready);
  assign enq_ready = slot_open(occ_q, deq_ready);
  assign load_evt  = hs_fire(enq_valid, enq_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) occ_q <= 1'b0;
    else        occ_q <= occ_next(occ_q, load_evt, drain_evt);
  end

  // R4
  drain_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_evt && !load_evt) |=> !deq_valid);

  // R5
  swap_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_evt && load_evt) |=> deq_valid);

endmodule

// File: rtl/pfifo_store.sv
module pfifo_store #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= din;
  end

  assign dout = word_q;

  // R7
  hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(dout));

endmodule

// File: rtl/pipe_fifo1.sv
module pipe_fifo1 #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  output logic             enq_ready,
  input  logic [WIDTH-1:0] enq_data,
  output logic             deq_valid,
  input  logic             deq_ready,
  output logic [WIDTH-1:0] deq_data
);

  logic load_evt;
  logic drain_evt;

  pfifo_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_valid (enq_valid),
    .deq_ready (deq_ready),
    .enq_ready (enq_ready),
    .deq_valid (deq_valid),
    .load_evt  (load_evt),
    .drain_evt (drain_evt)
  );

  pfifo_store #(.WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_evt),
    .din   (enq_data),
    .dout  (deq_data)
  );

  // R2
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (deq_valid && deq_data == $past(enq_data)));

  // R3
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && !deq_ready) |=> (deq_valid && $stable(deq_data)));

  // R6
  stall_blocks_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && !deq_ready) |-> !enq_ready);

endmodule

// File: tb/pipe_fifo1_tb.sv
`timescale 1ns/1ps
module pipe_fifo1_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enq_valid = 1'b0;
  logic         enq_ready;
  logic [W-1:0] enq_data = '0;
  logic         deq_valid;
  logic         deq_ready = 1'b0;
  logic [W-1:0] deq_data;

  always #2.5 clk = ~clk;

  pipe_fifo1 #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_data(enq_data),
    .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_data(deq_data)
  );

  int checks = 0;
  int errors = 0;
  int pops   = 0;
  logic         mdl_full = 1'b0;
  logic [W-1:0] mdl_data = '0;
  logic [W-1:0] sent_q[$];

  task automatic chk(input logic ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_enq_ready(input logic full, input logic rdy);
    return rdy | ~full;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // One cycle: drive at falling edge, check after settling, update model.
  task automatic cycle(input logic iv, input logic [W-1:0] id, input logic ordy);
    logic psh, pp;
    logic [W-1:0] exp;
    @(negedge clk);
    enq_valid = iv; enq_data = id; deq_ready = ordy;
    #1;
    chk(deq_valid == mdl_full, "R2 deq_valid", deq_valid, mdl_full);
    if (mdl_full) chk(deq_data == mdl_data, "R5 held word", deq_data, mdl_data);
    else          chk(deq_data == mdl_data, "R7 idle data", deq_data, mdl_data);
    chk(enq_ready == exp_enq_ready(mdl_full, ordy), "R6 enq_ready",
        enq_ready, exp_enq_ready(mdl_full, ordy));
    psh = iv && exp_enq_ready(mdl_full, ordy);
    pp  = mdl_full && ordy;
    if (pp) begin
      exp = sent_q.pop_front();
      chk(deq_data == exp, "R9 order", deq_data, exp);
      pops++;
    end
    if (psh) begin
      sent_q.push_back(id);
      mdl_data = id;
    end
    mdl_full = psh || (mdl_full && !pp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(deq_valid == 1'b0, "R1 deq_valid", deq_valid, 0);
    chk(enq_ready == 1'b1, "R1 enq_ready", enq_ready, 1);
    chk(deq_data == '0, "R1 data", deq_data, 0);
    rst_n = 1'b1;

    // R2 fill an empty buffer
    cycle(1'b1, 16'hA5A5, 1'b0);
    // R3 stalled consumer, write offered but refused
    cycle(1'b1, 16'h1111, 1'b0);
    chk(enq_ready == 1'b0, "R3 refuse", enq_ready, 0);
    cycle(1'b1, 16'h2222, 1'b0);
    chk(deq_data == 16'hA5A5, "R3 kept word", deq_data, 16'hA5A5);
    // R5 read and write together while full
    cycle(1'b1, 16'h3C3C, 1'b1);
    cycle(1'b0, 16'h0000, 1'b0);
    chk(deq_valid && deq_data == 16'h3C3C, "R5 swap", deq_data, 16'h3C3C);
    // R4 drain without refill
    cycle(1'b0, 16'hFFFF, 1'b1);
    cycle(1'b0, 16'hEEEE, 1'b0);
    chk(deq_valid == 1'b0, "R4 empty", deq_valid, 0);
    // R7 idle lane holds last word while input bus moves
    cycle(1'b0, 16'hDDDD, 1'b1);
    chk(deq_data == 16'h3C3C, "R7 hold", deq_data, 16'h3C3C);

    // R8 continuous stream
    begin
      int p0;
      p0 = pops;
      for (int i = 0; i < 40; i++) cycle(1'b1, W'(16'h4000 + i), 1'b1);
      chk((pops - p0) == 39, "R8 throughput", pops - p0, 39);
      cycle(1'b0, '0, 1'b1);
    end

    // R9 random stalls on both sides
    for (int i = 0; i < 3000; i++)
      cycle(1'($urandom % 3 != 0), W'($urandom), 1'($urandom % 2));
    for (int i = 0; i < 3; i++) cycle(1'b0, '0, 1'b1);
    chk(sent_q.size() == 0, "R9 no loss", sent_q.size(), 0);

    finish_run();
  end

endmodule